// File: doc/BRIEF.md
# SDRAM Open-Row Bank Tracker

This block follows the open-row state of every internal bank behind each SDRAM chip select, so that a memory controller's sequencer can choose the shortest command path for each access. It holds one valid flag and one row address per bank. Each request, given as a chip select, a bank and a row, is sorted in the same cycle into one of three classes. A page hit can go straight to a column command. A conflict needs a precharge and then an activate. An empty bank needs only an activate.

The state follows commands that the controller reports on a command-observed strobe. An activate opens a bank at a given row. A precharge closes one bank, or every bank of its chip select when address bit 10 of the command is high. A refresh or a self-refresh entry closes every bank of its chip select. A command changes the state at the next clock edge. A request presented in the same cycle as a command is therefore classified against the state from before that command.

Top module: `sdram_row_tracker`

## Requirements
- R1: After reset every bank of every chip select is closed, so every request is classified empty.
- R2: A command with `cmd_type` 2'b00 (activate) opens bank `cmd_bank` of chip select `cmd_cs` with row `cmd_addr`, starting with the next cycle.
- R3: When the addressed bank is open and its stored row equals `req_row`, `req_hit` is high and `req_open_row` shows the stored row.
- R4: When the addressed bank is open and its stored row differs from `req_row`, `req_conflict` is high and `req_open_row` shows the stored row.
- R5: When the addressed bank is closed, `req_empty` is high and `req_open_row` is zero.
- R6: A command with `cmd_type` 2'b01 (precharge) and `cmd_addr` bit 10 low closes only bank `cmd_bank` of `cmd_cs`. The other bits of `cmd_addr` have no effect.
- R7: A precharge with `cmd_addr` bit 10 high closes all four banks of `cmd_cs` and leaves the other chip select untouched.
- R8: A command with `cmd_type` 2'b10 (refresh) or 2'b11 (self-refresh entry) closes all banks of `cmd_cs` only.
- R9: The two chip selects keep independent state: an activate under one chip select never changes the classification of a request to the other.
- R10: Exactly one of `req_hit`, `req_conflict` and `req_empty` is high in every cycle.
- R11: A request in the same cycle as a command is classified on the state from before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_cs | input | 1 | Chip select of the request |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 11 | Row of the request |
| cmd_valid | input | 1 | A command was issued this cycle |
| cmd_type | input | 2 | 00 activate, 01 precharge, 10 refresh, 11 self-refresh entry |
| cmd_cs | input | 1 | Chip select of the command |
| cmd_bank | input | 2 | Bank of the command |
| cmd_addr | input | 11 | Row for activate; bit 10 selects all banks for precharge |
| req_hit | output | 1 | Open bank, same row |
| req_conflict | output | 1 | Open bank, different row |
| req_empty | output | 1 | Bank closed |
| req_open_row | output | 11 | Stored row of the addressed bank, zero when closed |

## Verification
The bench sends single-bank precharges whose low address bits are not zero. A design that decoded the wrong bit, or treated any nonzero address as precharge-all, would close banks that should stay open. Precharge-all, refresh and self-refresh are issued while the other chip select holds open rows, which exposes any leakage between chip selects. Requests are placed in the same cycle as an activate to the same bank; a design that forwarded the new state would report a hit where the answer must be empty. Long runs of mixed commands and requests then compare every output against a behavioural model on every clock, catching swapped row comparisons and stale rows left behind after a re-activate.

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int NUM_CS    = 2,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int ALL_BIT   = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [((NUM_CS>1)?$clog2(NUM_CS):1)-1:0]       req_cs,
  input  logic [((NUM_BANKS>1)?$clog2(NUM_BANKS):1)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_type,
  input  logic [((NUM_CS>1)?$clog2(NUM_CS):1)-1:0]       cmd_cs,
  input  logic [((NUM_BANKS>1)?$clog2(NUM_BANKS):1)-1:0] cmd_bank,
  input  logic [ROW_W-1:0]             cmd_addr,
  output logic                         req_hit,
  output logic                         req_conflict,
  output logic                         req_empty,
  output logic [ROW_W-1:0]             req_open_row
);
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int BK_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int SLOTS = NUM_CS * NUM_BANKS;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  localparam logic [1:0] CMD_ACT  = 2'b00;
  localparam logic [1:0] CMD_PRE  = 2'b01;
  localparam logic [1:0] CMD_REF  = 2'b10;
  localparam logic [1:0] CMD_SREF = 2'b11;

  logic [SLOTS-1:0] valid_q;
  logic [ROW_W-1:0] row_q [SLOTS];

  wire close_cs = cmd_valid && ((cmd_type == CMD_PRE && cmd_addr[ALL_BIT]) ||
                                cmd_type == CMD_REF || cmd_type == CMD_SREF);
  wire close_one = cmd_valid && cmd_type == CMD_PRE && !cmd_addr[ALL_BIT];
  wire open_one  = cmd_valid && cmd_type == CMD_ACT;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int C = g / NUM_BANKS;
    localparam int B = g % NUM_BANKS;
    wire on_cs   = (cmd_cs == CS_W'(C));
    wire on_bank = (cmd_bank == BK_W'(B));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        row_q[g]   <= '0;
      end else if (on_cs && open_one && on_bank) begin
        valid_q[g] <= 1'b1;
        row_q[g]   <= cmd_addr;
      end else if (on_cs && (close_cs || (close_one && on_bank))) begin
        valid_q[g] <= 1'b0;
      end
    end
  end

  wire [IDX_W-1:0] req_idx = IDX_W'(req_cs) * IDX_W'(NUM_BANKS) + IDX_W'(req_bank);
  wire [IDX_W-1:0] cmd_idx = IDX_W'(cmd_cs) * IDX_W'(NUM_BANKS) + IDX_W'(cmd_bank);
  wire             sel_valid = valid_q[req_idx];
  wire [ROW_W-1:0] sel_row   = row_q[req_idx];

  assign req_hit      = sel_valid && (sel_row == req_row);
  assign req_conflict = sel_valid && (sel_row != req_row);
  assign req_empty    = !sel_valid;
  assign req_open_row = sel_valid ? sel_row : '0;

  function automatic logic [NUM_BANKS-1:0] cs_flags(input logic [SLOTS-1:0] v,
                                                    input logic [CS_W-1:0] c);
    return NUM_BANKS'(v >> (int'(c) * NUM_BANKS));
  endfunction

  p_class_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_hit, req_conflict, req_empty}) == 1);

  p_hit_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |-> req_open_row == req_row);

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_one |=> valid_q[$past(cmd_idx)] && row_q[$past(cmd_idx)] == $past(cmd_addr));

  p_pre_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close_one |=> !valid_q[$past(cmd_idx)]);

  p_pre_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == CMD_PRE && cmd_addr[ALL_BIT]) |=>
      cs_flags(valid_q, $past(cmd_cs)) == '0);

  p_refresh_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_type == CMD_REF || cmd_type == CMD_SREF)) |=>
      cs_flags(valid_q, $past(cmd_cs)) == '0);

  p_other_cs_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> cs_flags(valid_q, ~$past(cmd_cs)) == cs_flags($past(valid_q), ~$past(cmd_cs)));
endmodule

// File: tb/tb_sdram_row_tracker.sv
module tb_sdram_row_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_cs = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [10:0] req_row = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_type = '0;
  logic        cmd_cs = 1'b0;
  logic [1:0]  cmd_bank = '0;
  logic [10:0] cmd_addr = '0;
  logic        req_hit, req_conflict, req_empty;
  logic [10:0] req_open_row;

  int checks = 0;
  int fails = 0;
  bit mv [2][4];
  int mr [2][4];

  always #10 clk = ~clk;

  sdram_row_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .req_cs(req_cs), .req_bank(req_bank), .req_row(req_row),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_cs(cmd_cs),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .req_hit(req_hit), .req_conflict(req_conflict),
    .req_empty(req_empty), .req_open_row(req_open_row)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic compare(string tag);
    bit v;
    bit eh, ec, ee;
    int er;
    v  = mv[req_cs][req_bank];
    eh = v && (mr[req_cs][req_bank] == int'(req_row));
    ec = v && (mr[req_cs][req_bank] != int'(req_row));
    ee = !v;
    er = v ? mr[req_cs][req_bank] : 0;
    checks++;
    if (req_hit !== eh || req_conflict !== ec || req_empty !== ee || int'(req_open_row) != er) begin
      fails++;
      $display("FAIL %s: cs%0d bank%0d row %h got hit/conf/empty=%b%b%b open=%h exp %b%b%b open=%h",
               tag, req_cs, req_bank, req_row, req_hit, req_conflict, req_empty, req_open_row,
               eh, ec, ee, er);
    end
  endtask

  task automatic model_cmd();
    if (!cmd_valid) return;
    case (cmd_type)
      2'b00: begin mv[cmd_cs][cmd_bank] = 1; mr[cmd_cs][cmd_bank] = int'(cmd_addr); end
      2'b01: begin
        if (cmd_addr[10]) for (int b = 0; b < 4; b++) mv[cmd_cs][b] = 0;
        else mv[cmd_cs][cmd_bank] = 0;
      end
      default: for (int b = 0; b < 4; b++) mv[cmd_cs][b] = 0;
    endcase
  endtask

  task automatic step(string tag, bit cv, logic [1:0] ct, int ccs, int cbk, int caddr,
                      int rcs, int rbk, int rrow);
    cmd_valid = cv; cmd_type = ct; cmd_cs = ccs[0]; cmd_bank = cbk[1:0];
    cmd_addr = caddr[10:0];
    req_cs = rcs[0]; req_bank = rbk[1:0]; req_row = rrow[10:0];
    #2;
    compare(tag);
    @(posedge clk);
    model_cmd();
    @(negedge clk);
  endtask

  task automatic probe(string tag, int rcs, int rbk, int rrow);
    step(tag, 0, 2'b00, 0, 0, 0, rcs, rbk, rrow);
  endtask

  initial begin
    #4_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    summary();
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int b = 0; b < 4; b++) begin mv[c][b] = 0; mr[c][b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: everything closed after reset
    for (int i = 0; i < 8; i++) probe("R1", i / 4, i % 4, i * 37);

    // R2 / R3 / R4 / R9
    step("R2", 1, 2'b00, 0, 1, 'h155, 0, 1, 'h155);
    probe("R3", 0, 1, 'h155);
    probe("R4", 0, 1, 'h154);
    probe("R9", 1, 1, 'h155);
    probe("R5", 0, 0, 'h155);

    // R11: same-cycle activate does not forward
    step("R11", 1, 2'b00, 0, 2, 'h7ff, 0, 2, 'h7ff);
    probe("R11", 0, 2, 'h7ff);
    step("R11", 1, 2'b00, 0, 2, 'h003, 0, 2, 'h7ff);
    probe("R2", 0, 2, 'h003);

    // open all cs0 banks and two cs1 banks
    for (int b = 0; b < 4; b++) step("R2", 1, 2'b00, 0, b, 'h100 + b, 0, b, 'h100 + b);
    step("R9", 1, 2'b00, 1, 0, 'h2aa, 0, 0, 'h100);
    step("R9", 1, 2'b00, 1, 3, 'h0f0, 1, 0, 'h2aa);
    for (int b = 0; b < 4; b++) probe("R9", 0, b, 'h100 + b);

    // R6: single precharge with noise in low bits
    step("R6", 1, 2'b01, 0, 1, 'h3ff, 0, 1, 'h101);
    for (int b = 0; b < 4; b++) probe("R6", 0, b, 'h100 + b);
    probe("R6", 1, 0, 'h2aa);

    // R7: precharge-all on cs0 leaves cs1 alone
    step("R7", 1, 2'b01, 0, 2, 'h400, 0, 0, 'h100);
    for (int b = 0; b < 4; b++) probe("R7", 0, b, 'h100 + b);
    probe("R7", 1, 0, 'h2aa);
    probe("R7", 1, 3, 'h0f0);

    // R8: refresh on cs1, self-refresh on cs0
    step("R8", 1, 2'b00, 0, 3, 'h011, 1, 3, 'h0f0);
    step("R8", 1, 2'b10, 1, 0, 'h000, 1, 3, 'h0f0);
    probe("R8", 1, 0, 'h2aa);
    probe("R8", 1, 3, 'h0f0);
    probe("R8", 0, 3, 'h011);
    step("R8", 1, 2'b11, 0, 0, 'h000, 0, 3, 'h011);
    probe("R8", 0, 3, 'h011);

    // R10: long mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom % 16);
      step("R10", $urandom % 3 != 0,
           (r < 9) ? 2'b00 : (r < 14) ? 2'b01 : (r == 14) ? 2'b10 : 2'b11,
           int'($urandom % 2), int'($urandom % 4),
           (r < 9) ? int'($urandom % 8) : int'($urandom % 2048),
           int'($urandom % 2), int'($urandom % 4), int'($urandom % 8));
    end

    summary();
  end
endmodule